// File: doc/BRIEF.md
# Flash Write Qualifier and Sector Protect Gate

This block sits between the control pins of a parallel NOR flash and its command logic. It samples chip enable, write enable and output enable (all active low) on the system clock. It turns a valid bus write into a single-cycle strobe. It holds one protect bit per sector and gives each sector a write-enable that program and erase must honour. The inputs are taken to be synchronous to `clk`.

A write is refused in four cases:
- the pins are in the wrong state;
- the pins did not hold the write state long enough;
- the supply is below its lockout level;
- the pins were already in the write state when power-up or supply recovery completed.

Two digital flags report a high voltage on the reset pin and on address pin 9. While the reset-pin flag is held, protection is lifted for the time being. The same flags, combined with a fixed address pattern on a write, raise a request to clear protection for good.

Top module: `flash_wr_gate`

## Requirements
- R1: `wr_stb` is high for exactly one cycle, in the cycle after the first clock sample at which the write state (CE low, WE low, OE high) is no longer present. This happens only when that state had held for at least GLITCH_N consecutive samples. A state held longer still gives one strobe.
- R2: No strobe results when OE is low, CE is high or WE is high, however long the other pins stay in their write levels.
- R3: A write state held for fewer than GLITCH_N consecutive samples gives no strobe.
- R4: While `supply_ok` is low, no write is accepted and every bit of `sec_we` is 0. `rd_force` is 1 from the cycle after `supply_ok` is sampled low.
- R5: A write state that is already present when `supply_ok` returns high is not accepted. WE must first be sampled high, and a fresh write is then needed.
- R6: While `por_n` is low, `wr_stb` and `unprot_req` are 0, `rd_force` is 1 and all protect bits are cleared. If WE and CE are low with OE high when reset ends, the following WE rise is not accepted, and `sec_we` stays all 0 until WE is sampled high.
- R7: A `prot_set` pulse sets the protect bit of sector `sec_idx`. With no high-voltage flag, `sec_we[i]` is 1 exactly when sector i is unprotected.
- R8: While `hv_rst` is 1 (and supply and lockout allow), every bit of `sec_we` is 1. When `hv_rst` returns to 0, the sectors that were protected read 0 again, because the stored bits are unchanged.
- R9: `unprot_req` pulses together with `wr_stb` only when `hv_rst` or `hv_a9` is 1 and, on the closing sample, addr[6]=1, addr[1]=1 and addr[0]=0. Otherwise it stays 0.
- R10: `hv_a9` alone does not change `sec_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| supply_ok | input | 1 | Supply above lockout level |
| ce_n | input | 1 | Chip enable pin, active low |
| we_n | input | 1 | Write enable pin, active low |
| oe_n | input | 1 | Output enable pin, active low |
| hv_rst | input | 1 | High voltage present on the reset pin |
| hv_a9 | input | 1 | High voltage present on address pin 9 |
| addr | input | 7 | Low address bits used for the unprotect pattern |
| sec_idx | input | $clog2(NSECT) | Sector selected by `prot_set` |
| prot_set | input | 1 | Set the protect bit of `sec_idx` |
| wr_stb | output | 1 | Qualified write strobe, one cycle |
| unprot_req | output | 1 | Permanent unprotect request, one cycle |
| rd_force | output | 1 | Hold command logic in read mode |
| sec_we | output | NSECT | Per-sector program/erase enable |

## Verification
The bench uses a write state of GLITCH_N-1 samples to check that a filter one sample too short gets no strobe. A state held well past the minimum checks for exactly one strobe rather than one per sample. It brings `supply_ok` back while WE is still low, and it releases reset with WE low. A design without the lockout would emit a strobe on the next WE rise in both cases. It also toggles `hv_rst` with protected sectors present. A design that wrote through the temporary mode into the protect bits would leave those sectors open after the flag drops. Finally, the unprotect pattern is checked with one address bit wrong and with no high-voltage flag, both of which must give no request.

// File: rtl/flash_wr_gate.sv
module flash_wr_gate #(
  parameter int NSECT    = 8,
  parameter int GLITCH_N = 2,
  localparam int SECW    = (NSECT > 1) ? $clog2(NSECT) : 1,
  localparam int CW      = $clog2(GLITCH_N + 1)
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             supply_ok,
  input  logic             ce_n,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic             hv_rst,
  input  logic             hv_a9,
  input  logic [6:0]       addr,
  input  logic [SECW-1:0]  sec_idx,
  input  logic             prot_set,
  output logic             wr_stb,
  output logic             unprot_req,
  output logic             rd_force,
  output logic [NSECT-1:0] sec_we
);

  logic [CW-1:0]    cnt;
  logic             plk;
  logic [NSECT-1:0] prot;

  wire pin_ok = !ce_n && !we_n && oe_n;
  wire live   = pin_ok && supply_ok && !plk;
  wire armed  = (cnt == CW'(GLITCH_N));
  wire ending = armed && !live && supply_ok;
  wire magic  = (hv_rst || hv_a9) && addr[6] && addr[1] && !addr[0];

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt        <= '0;
      plk        <= 1'b1;
      prot       <= '0;
      wr_stb     <= 1'b0;
      unprot_req <= 1'b0;
      rd_force   <= 1'b1;
    end else begin
      if (!supply_ok)  plk <= 1'b1;
      else if (we_n)   plk <= 1'b0;
      if (!live)       cnt <= '0;
      else if (!armed) cnt <= cnt + CW'(1);
      wr_stb     <= ending;
      unprot_req <= ending && magic;
      rd_force   <= !supply_ok;
      if (prot_set) prot[sec_idx] <= 1'b1;
    end
  end

  assign sec_we = (~prot | {NSECT{hv_rst}}) & {NSECT{supply_ok && !plk}};

  // R1
  stb_single_chk: assert property (@(posedge clk) disable iff (!por_n)
    wr_stb |=> !wr_stb);
  // R4
  supply_stb_chk: assert property (@(posedge clk) disable iff (!por_n)
    !supply_ok |=> !wr_stb);
  // R4
  rd_force_chk: assert property (@(posedge clk) disable iff (!por_n)
    !supply_ok |=> rd_force);
  // R6
  lockout_chk: assert property (@(posedge clk) disable iff (!por_n)
    (plk && !we_n) |=> !wr_stb);
  // R8
  prot_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
    (hv_rst && !prot_set) |=> $stable(prot));
  // R9
  unprot_chk: assert property (@(posedge clk) disable iff (!por_n)
    unprot_req |-> wr_stb);

endmodule

// File: tb/flash_wr_gate_test.sv
module flash_wr_gate_test;
  localparam int NSECT = 8;
  localparam int GN    = 2;

  logic clk = 0, por_n = 0, supply_ok = 1;
  logic ce_n = 0, we_n = 0, oe_n = 1;
  logic hv_rst = 0, hv_a9 = 0, prot_set = 0;
  logic [6:0] addr = '0;
  logic [2:0] sec_idx = '0;
  logic wr_stb, unprot_req, rd_force;
  logic [NSECT-1:0] sec_we;
  int total = 0, bad = 0, stbs = 0, ups = 0;
  logic [NSECT-1:0] mask = '0;

  always #2 clk = ~clk;

  flash_wr_gate #(.NSECT(NSECT), .GLITCH_N(GN)) uut (
    .clk(clk), .por_n(por_n), .supply_ok(supply_ok), .ce_n(ce_n), .we_n(we_n),
    .oe_n(oe_n), .hv_rst(hv_rst), .hv_a9(hv_a9), .addr(addr), .sec_idx(sec_idx),
    .prot_set(prot_set), .wr_stb(wr_stb), .unprot_req(unprot_req),
    .rd_force(rd_force), .sec_we(sec_we));

  always @(negedge clk) begin
    if (wr_stb) stbs++;
    if (unprot_req) ups++;
  end

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(int n, logic [6:0] a, logic oe = 1, logic ce = 0);
    @(negedge clk);
    addr = a; ce_n = ce; we_n = 0; oe_n = oe;
    cyc(n);
    we_n = 1; ce_n = 1; oe_n = 1;
    cyc(3);
  endtask

  task automatic t_powerup;
    cyc(3);
    check(wr_stb == 0, "R6 stb in reset", wr_stb, 0);
    check(rd_force == 1, "R6 rd_force in reset", rd_force, 1);
    check(unprot_req == 0, "R6 unprot in reset", unprot_req, 0);
    por_n = 1;
    cyc(4);
    check(sec_we == 0, "R6 sec_we under lockout", sec_we, 0);
    we_n = 1; ce_n = 1;
    cyc(3);
    check(stbs == 0, "R6 WE rise after power-up", stbs, 0);
    check(sec_we == '1, "R6 protect bits cleared", sec_we, 255);
    check(rd_force == 0, "R6 rd_force released", rd_force, 0);
  endtask

  task automatic t_write;
    int s0 = stbs;
    bus_write(GN, 7'h00);
    check(stbs - s0 == 1, "R1 minimum write", stbs - s0, 1);
    s0 = stbs;
    bus_write(6, 7'h00);
    check(stbs - s0 == 1, "R1 long write single strobe", stbs - s0, 1);
  endtask

  task automatic t_glitch;
    int s0 = stbs;
    bus_write(GN - 1, 7'h00);
    check(stbs - s0 == 0, "R3 short pulse", stbs - s0, 0);
  endtask

  task automatic t_blocked;
    int s0 = stbs;
    bus_write(5, 7'h00, 1'b0, 1'b0);
    check(stbs - s0 == 0, "R2 OE low", stbs - s0, 0);
    bus_write(5, 7'h00, 1'b1, 1'b1);
    check(stbs - s0 == 0, "R2 CE high", stbs - s0, 0);
  endtask

  task automatic t_supply_low;
    int s0 = stbs;
    @(negedge clk) supply_ok = 0;
    cyc(2);
    check(rd_force == 1, "R4 rd_force", rd_force, 1);
    check(sec_we == 0, "R4 sec_we", sec_we, 0);
    bus_write(4, 7'h00);
    check(stbs - s0 == 0, "R4 write ignored", stbs - s0, 0);
    supply_ok = 1;
    cyc(2);
    check(rd_force == 0, "R4 rd_force drops", rd_force, 0);
  endtask

  task automatic t_supply_mid;
    int s0 = stbs;
    @(negedge clk) supply_ok = 0; ce_n = 0; we_n = 0; oe_n = 1;
    cyc(3);
    supply_ok = 1;
    cyc(4);
    we_n = 1; ce_n = 1;
    cyc(3);
    check(stbs - s0 == 0, "R5 cycle open at supply return", stbs - s0, 0);
    bus_write(GN, 7'h00);
    check(stbs - s0 == 1, "R5 fresh write after return", stbs - s0, 1);
  endtask

  task automatic t_protect;
    foreach (mask[i]) if (i == 2 || i == 5) begin
      @(negedge clk) prot_set = 1; sec_idx = 3'(i);
      @(negedge clk) prot_set = 0;
    end
    mask = 8'b0010_0100;
    cyc(1);
    check(sec_we == ~mask, "R7 protect mask", sec_we, ~mask);
  endtask

  task automatic t_temp;
    @(negedge clk) hv_rst = 1;
    cyc(1);
    check(sec_we == '1, "R8 temporary unprotect", sec_we, 255);
    @(negedge clk) hv_rst = 0;
    cyc(1);
    check(sec_we == ~mask, "R8 protection restored", sec_we, ~mask);
    @(negedge clk) hv_a9 = 1;
    cyc(1);
    check(sec_we == ~mask, "R10 A9 flag no effect", sec_we, ~mask);
    @(negedge clk) hv_a9 = 0;
  endtask

  task automatic t_unprot;
    int u0 = ups;
    hv_rst = 1;
    bus_write(GN, 7'b100_0010);
    check(ups - u0 == 1, "R9 reset-pin flag", ups - u0, 1);
    hv_rst = 0; hv_a9 = 1;
    bus_write(GN, 7'b100_0010);
    check(ups - u0 == 2, "R9 A9 flag", ups - u0, 2);
    bus_write(GN, 7'b100_0011);
    check(ups - u0 == 2, "R9 wrong A0", ups - u0, 2);
    hv_a9 = 0;
    bus_write(GN, 7'b100_0010);
    check(ups - u0 == 2, "R9 no flag", ups - u0, 2);
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_powerup();
    t_write();
    t_glitch();
    t_blocked();
    t_supply_low();
    t_supply_mid();
    t_protect();
    t_temp();
    t_unprot();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule